// File: doc/BRIEF.md
# Linked-Descriptor Transfer Engine

This block moves words between memory and a device-side stream without processor involvement. Software builds a list of four-word descriptors in memory, each naming a direction, a data address, a word count and the address of the following descriptor. It loads the address of the first descriptor into the list-pointer register and then writes the go register. From that point the engine works through the list one descriptor at a time. For each one it reads the descriptor, moves the data, and writes a completion mark back into the descriptor's control word. It then follows the link.

A zero link means the list may have ended. Before stopping, the engine reads that link word from memory one more time. This lets software append a descriptor while the engine is still running, as long as it writes the link before the re-read. A descriptor can ask for an interrupt when it completes. The interrupt is held as a sticky status flag and drives the interrupt pin. It stays set until software clears it. Memory is reached through a plain request port. A write completes in the cycle it is requested. A read returns its data with one response pulse, after any latency.

Top module: `dma_chain_engine`

## Requirements
- R1: Register index 0 holds the address of the first descriptor and reads back what was written. Reading the go register (index 1) or the interrupt-clear register (index 3) returns 0.
- R2: A write of any value to the go register while the engine is idle starts the walk at the descriptor addressed by register 0. It also clears the list-finished flag.
- R3: A descriptor occupies four consecutive words. Word 0 is the control word: bit 0 gives the direction (0 = memory to device, 1 = device to memory), bit 1 requests an interrupt, and bit 31 is the completion mark. Word 1 is the data address, word 2 is the word count and word 3 is the next-descriptor address. Only one memory read is outstanding at any time.
- R4: In the memory-to-device direction, the engine reads count words from consecutive addresses starting at the data address. It presents them on the tx stream in address order. Each word is held stable until it is accepted.
- R5: In the device-to-memory direction, the engine writes count words taken from the rx stream to consecutive addresses starting at the data address. It never drives tx valid and rx ready at the same time.
- R6: After its data has moved, a descriptor is retired. Its control word is written back with bit 31 set and all other bits unchanged.
- R7: A descriptor with a count of 0 moves no data and is still retired.
- R8: When the next-descriptor address is 0, the engine reads word 3 of the same descriptor from memory once more. If that read returns a nonzero value, the engine continues at that address.
- R9: When the re-read link is also 0, the engine goes idle. Status bit 0 (busy) is then 0 and status bit 1 (list finished) is 1.
- R10: Retiring a descriptor whose interrupt bit is set raises status bit 2 and the irq pin. Both stay set until a write to register 3 with bit 0 = 1.
- R11: A go write with register 0 equal to 0 finishes the list at once and sets the list-finished flag, with no memory request. The engine issues no memory request while it is idle.
- R12: A write to the status register (index 2) has no effect. After reset, status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 list pointer, 1 go, 2 status, 3 interrupt clear) |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from reg_addr |
| irq | output | 1 | Level interrupt, mirrors status bit 2 |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rvalid | input | 1 | Read response pulse |
| mem_rdata | input | DW | Read response data |
| tx_valid | output | 1 | Word offered to the device |
| tx_data | output | DW | Word to the device |
| tx_ready | input | 1 | Device accepts the offered word |
| rx_valid | input | 1 | Device offers a word |
| rx_data | input | DW | Word from the device |
| rx_ready | output | 1 | Engine accepts the offered word |

## Verification
The bench builds the engine with a 12-bit word address and 32-bit data. A 4096-word memory model then covers the whole address space. Every descriptor pointer, data buffer and sentinel lies inside that space, so the bench can inspect any of them after a run. Read latency is random, and so are the ready and valid patterns on both device streams. Together these reach the cases where a tx word stalls, an rx word arrives late, and a read response is delayed. A late append is placed in the single cycle between a descriptor's retirement and the engine's re-read of its link.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam logic [1:0] REG_HEAD   = 2'd0;
    localparam logic [1:0] REG_GO     = 2'd1;
    localparam logic [1:0] REG_STATUS = 2'd2;
    localparam logic [1:0] REG_CLEAR  = 2'd3;

    localparam int CTL_DIR_BIT = 0;
    localparam int CTL_IRQ_BIT = 1;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_FWAIT,
        S_RD,
        S_RWAIT,
        S_TX,
        S_RX,
        S_RETIRE,
        S_LINK,
        S_RECHK,
        S_RCWAIT
    } seq_state_e;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          busy_i,
    input  logic          blk_irq_i,
    input  logic          chain_end_i,
    output logic          start_o,
    output logic [AW-1:0] head_o,
    output logic          irq_o
);

    typedef struct packed {
        logic [AW-1:0] head;
        logic          done;
        logic          irq;
    } regs_t;

    regs_t q, d;
    logic  clr_wr;

    assign clr_wr  = reg_wr && (reg_addr == REG_CLEAR) && reg_wdata[0];
    assign start_o = reg_wr && (reg_addr == REG_GO) && !busy_i;

    always_comb begin
        d = q;
        if (reg_wr && reg_addr == REG_HEAD) d.head = reg_wdata[AW-1:0];
        if (start_o) d.done = 1'b0;
        if (chain_end_i) d.done = 1'b1;
        if (clr_wr) d.irq = 1'b0;
        if (blk_irq_i) d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (reg_addr)
            REG_HEAD:   reg_rdata = DW'(q.head);
            REG_STATUS: reg_rdata = DW'({q.irq, q.done, busy_i});
            default:    reg_rdata = '0;
        endcase
    end

    assign head_o = q.head;
    assign irq_o  = q.irq;

    // R10
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq && !clr_wr |=> q.irq);

    // R9
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_end_i |=> q.done && !busy_i);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] head_i,
    output logic          busy_o,
    output logic          blk_irq_o,
    output logic          chain_end_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic          mem_rvalid_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          tx_valid_o,
    output logic [DW-1:0] tx_data_o,
    input  logic          tx_ready_i,
    input  logic          rx_valid_i,
    input  logic [DW-1:0] rx_data_i,
    output logic          rx_ready_o
);

    localparam int DONE_BIT = DW - 1;
    localparam logic [AW-1:0] LINK_OFS = AW'(3);

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] cur;
        logic [1:0]    idx;
        logic [DW-1:0] ctrl;
        logic [AW-1:0] daddr;
        logic [DW-1:0] cnt;
        logic [AW-1:0] nxt;
        logic [DW-1:0] word;
    } seq_t;

    seq_t q, d;
    logic last_word;

    assign last_word = (q.cnt == DW'(1));

    always_comb begin
        d           = q;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        tx_valid_o  = 1'b0;
        tx_data_o   = q.word;
        rx_ready_o  = 1'b0;
        blk_irq_o   = 1'b0;
        chain_end_o = 1'b0;

        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    if (head_i == '0) begin
                        chain_end_o = 1'b1;
                    end else begin
                        d.cur = head_i;
                        d.idx = 2'd0;
                        d.st  = S_FETCH;
                    end
                end
            end
            S_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.cur + AW'(q.idx);
                d.st       = S_FWAIT;
            end
            S_FWAIT: begin
                if (mem_rvalid_i) begin
                    unique case (q.idx)
                        2'd0: d.ctrl  = mem_rdata_i;
                        2'd1: d.daddr = mem_rdata_i[AW-1:0];
                        2'd2: d.cnt   = mem_rdata_i;
                        2'd3: d.nxt   = mem_rdata_i[AW-1:0];
                    endcase
                    if (q.idx == 2'd3) begin
                        if (q.cnt == '0)                 d.st = S_RETIRE;
                        else if (q.ctrl[CTL_DIR_BIT])    d.st = S_RX;
                        else                             d.st = S_RD;
                    end else begin
                        d.idx = q.idx + 2'd1;
                        d.st  = S_FETCH;
                    end
                end
            end
            S_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.daddr;
                d.st       = S_RWAIT;
            end
            S_RWAIT: begin
                if (mem_rvalid_i) begin
                    d.word = mem_rdata_i;
                    d.st   = S_TX;
                end
            end
            S_TX: begin
                tx_valid_o = 1'b1;
                if (tx_ready_i) begin
                    d.daddr = q.daddr + AW'(1);
                    d.cnt   = q.cnt - DW'(1);
                    d.st    = last_word ? S_RETIRE : S_RD;
                end
            end
            S_RX: begin
                rx_ready_o = 1'b1;
                if (rx_valid_i) begin
                    mem_req_o   = 1'b1;
                    mem_we_o    = 1'b1;
                    mem_addr_o  = q.daddr;
                    mem_wdata_o = rx_data_i;
                    d.daddr     = q.daddr + AW'(1);
                    d.cnt       = q.cnt - DW'(1);
                    d.st        = last_word ? S_RETIRE : S_RX;
                end
            end
            S_RETIRE: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = q.cur;
                mem_wdata_o = q.ctrl | (DW'(1) << DONE_BIT);
                blk_irq_o   = q.ctrl[CTL_IRQ_BIT];
                d.st        = S_LINK;
            end
            S_LINK: begin
                if (q.nxt != '0) begin
                    d.cur = q.nxt;
                    d.idx = 2'd0;
                    d.st  = S_FETCH;
                end else begin
                    d.st = S_RECHK;
                end
            end
            S_RECHK: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.cur + LINK_OFS;
                d.st       = S_RCWAIT;
            end
            S_RCWAIT: begin
                if (mem_rvalid_i) begin
                    if (mem_rdata_i[AW-1:0] != '0) begin
                        d.cur = mem_rdata_i[AW-1:0];
                        d.idx = 2'd0;
                        d.st  = S_FETCH;
                    end else begin
                        chain_end_o = 1'b1;
                        d.st        = S_IDLE;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = (q.st != S_IDLE);

    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

    // R5
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid_o && rx_ready_o));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE) |-> !mem_req_o);

    // R3
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid_i |-> (q.st == S_FWAIT || q.st == S_RWAIT || q.st == S_RCWAIT));

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    input  logic          tx_ready,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    output logic          rx_ready
);

    logic          busy;
    logic          blk_irq;
    logic          chain_end;
    logic          start;
    logic [AW-1:0] head;

    dma_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .busy_i      (busy),
        .blk_irq_i   (blk_irq),
        .chain_end_i (chain_end),
        .start_o     (start),
        .head_o      (head),
        .irq_o       (irq)
    );

    dma_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .head_i       (head),
        .busy_o       (busy),
        .blk_irq_o    (blk_irq),
        .chain_end_o  (chain_end),
        .mem_req_o    (mem_req),
        .mem_we_o     (mem_we),
        .mem_addr_o   (mem_addr),
        .mem_wdata_o  (mem_wdata),
        .mem_rvalid_i (mem_rvalid),
        .mem_rdata_i  (mem_rdata),
        .tx_valid_o   (tx_valid),
        .tx_data_o    (tx_data),
        .tx_ready_i   (tx_ready),
        .rx_valid_i   (rx_valid),
        .rx_data_i    (rx_data),
        .rx_ready_o   (rx_ready)
    );

endmodule

// File: tb/dma_chain_engine_bench.sv
module dma_chain_engine_bench;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam int NB = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          tx_valid, tx_ready = 1'b0;
    logic [DW-1:0] tx_data;
    logic          rx_valid = 1'b0, rx_ready;
    logic [DW-1:0] rx_val = 32'h1000;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [DW-1:0] mem [0:4095];
    logic [DW-1:0] txlog [0:4095];
    int            txn = 0;
    int            reqcount = 0;
    logic          pend = 1'b0;
    logic [AW-1:0] paddr = '0;
    int            pwait = 0;
    logic          watch_en = 1'b0;
    logic [AW-1:0] watch_addr = '0;
    logic          hit = 1'b0;

    always #2.5 clk = ~clk;

    dma_chain_engine #(.AW(AW), .DW(DW)) u_dma_chain_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_val), .rx_ready(rx_ready)
    );

    // memory model: writes land at the edge, reads answer after a random wait
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) reqcount <= reqcount + 1;
        if (mem_req && mem_we) begin
            mem[mem_addr] <= mem_wdata;
            if (watch_en && mem_addr == watch_addr) hit <= 1'b1;
        end
        if (mem_req && !mem_we) begin
            pend  <= 1'b1;
            paddr <= mem_addr;
            pwait <= int'($urandom % 3);
        end else if (pend) begin
            if (pwait == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[paddr];
                pend       <= 1'b0;
            end else begin
                pwait <= pwait - 1;
            end
        end
        if (tx_valid && tx_ready) begin
            txlog[txn] <= tx_data;
            txn <= txn + 1;
        end
        if (rx_valid && rx_ready) rx_val <= rx_val + 1;
    end

    always @(negedge clk) begin
        tx_ready <= ($urandom % 4) != 0;
        rx_valid <= ($urandom % 4) != 0;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [DW-1:0] s;
        for (int n = 0; n < 20000; n++) begin
            @(negedge clk);
            rd(2'd2, s);
            if (!s[0]) return;
        end
    endtask

    function automatic logic [DW-1:0] ctl(input bit dir, input bit irqb);
        return {30'h0, irqb, dir};
    endfunction

    task automatic put_desc(input int b, input logic [DW-1:0] c, input int a,
                            input int n, input int nx);
        mem[b] = c; mem[b+1] = DW'(a); mem[b+2] = DW'(n); mem[b+3] = DW'(nx);
    endtask

    task automatic run_round(input int r);
        bit            dir [NB];
        bit            irb [NB];
        int            cnt [NB];
        int            dbase, bbase, tx0, txe, rxk;
        logic [DW-1:0] rx0, s;
        bit            any_irq;
        dbase = 16'h040 + r * 32;
        bbase = 16'h400 + r * 16'h200;
        any_irq = 1'b0;
        for (int i = 0; i < NB; i++) begin
            dir[i] = ($urandom % 2) != 0;
            cnt[i] = (i == 2) ? 0 : 1 + int'($urandom % 7);
            irb[i] = (i == r);
            any_irq |= irb[i];
            for (int k = 0; k < 32; k++)
                mem[bbase + i*32 + k] = dir[i] ? 32'hDEAD0000 + DW'(k) : $urandom;
            put_desc(dbase + i*4, ctl(dir[i], irb[i]) | 32'h0000_0F00, bbase + i*32,
                     cnt[i], (i == NB-1) ? 0 : dbase + (i+1)*4);
        end
        tx0 = txn;
        rx0 = rx_val;
        wr(2'd0, DW'(dbase));
        wr(2'd1, 32'h1);
        wait_idle();
        txe = 0;
        rxk = 0;
        for (int i = 0; i < NB; i++) begin
            int a;
            a = bbase + i*32;
            for (int k = 0; k < cnt[i]; k++) begin
                if (!dir[i]) begin
                    // R4 words leave in address order
                    chk(txlog[tx0 + txe] == mem[a+k], "R4", txlog[tx0 + txe], mem[a+k]);
                    txe++;
                end else begin
                    // R5 rx words land in consecutive addresses
                    chk(mem[a+k] == rx0 + DW'(rxk), "R5", mem[a+k], rx0 + DW'(rxk));
                    rxk++;
                end
            end
            if (cnt[i] == 0)  // R7 zero count touches no data
                chk(mem[a] == (dir[i] ? 32'hDEAD0000 : mem[a]) && mem[a+1] == mem[a+1],
                    "R7", mem[a], mem[a]);
            // R6 completion mark, other bits kept
            chk(mem[dbase + i*4] == (ctl(dir[i], irb[i]) | 32'h8000_0F00), "R6",
                mem[dbase + i*4], ctl(dir[i], irb[i]) | 32'h8000_0F00);
        end
        // R7 nothing extra went out to the device
        chk(txn - tx0 == txe, "R7", DW'(txn - tx0), DW'(txe));
        rd(2'd2, s);
        // R9 idle and finished
        chk(s[1:0] == 2'b10, "R9", s, 32'h2 | (s & 32'h4));
        // R10 sticky interrupt
        chk(s[2] == any_irq && irq == any_irq, "R10", {s[2], irq}, {any_irq, any_irq});
        wr(2'd3, 32'h0);
        rd(2'd2, s);
        chk(s[2] == any_irq, "R10", s[2], any_irq);
        wr(2'd3, 32'h1);
        rd(2'd2, s);
        chk(s[2] == 1'b0 && irq == 1'b0, "R10", {s[2], irq}, 2'b00);
    endtask

    initial begin
        logic [DW-1:0] s;
        int            rq;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(2'd2, s);
        chk(s == '0 && irq == 1'b0, "R12", s, '0);

        wr(2'd0, 32'h0000_0ABC);
        rd(2'd0, s);
        chk(s == 32'h0000_0ABC, "R1", s, 32'h0000_0ABC);
        rd(2'd1, s);
        chk(s == '0, "R1", s, '0);
        rd(2'd3, s);
        chk(s == '0, "R1", s, '0);

        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, s);
        chk(s == '0, "R12", s, '0);

        // R11 empty list
        wr(2'd0, 32'h0);
        rq = reqcount;
        wr(2'd1, 32'h1);
        repeat (4) @(negedge clk);
        rd(2'd2, s);
        chk(s == 32'h2, "R11", s, 32'h2);
        chk(reqcount == rq, "R11", DW'(reqcount), DW'(rq));

        // R2 start clears the finished flag while running
        put_desc(16'h020, ctl(1'b0, 1'b0), 16'h300, 7, 0);
        wr(2'd0, 32'h20);
        wr(2'd1, 32'h1);
        rd(2'd2, s);
        chk(s[1:0] == 2'b01, "R2", s, 32'h1);
        wait_idle();

        for (int r = 0; r < 4; r++) run_round(r);

        // R8 late append between retire and link re-read
        put_desc(16'h010, ctl(1'b0, 1'b0), 16'h380, 3, 0);
        put_desc(16'h018, ctl(1'b1, 1'b0), 16'h390, 2, 0);
        mem[16'h390] = 32'hDEAD_0000;
        mem[16'h391] = 32'hDEAD_0000;
        hit = 1'b0;
        watch_addr = 12'h010;
        watch_en = 1'b1;
        begin
            logic [DW-1:0] r0;
            r0 = rx_val;
            wr(2'd0, 32'h10);
            wr(2'd1, 32'h1);
            for (int n = 0; n < 5000 && !hit; n++) @(negedge clk);
            mem[16'h013] = 32'h18;
            wait_idle();
            watch_en = 1'b0;
            chk(mem[16'h018] == 32'h8000_0001, "R8", mem[16'h018], 32'h8000_0001);
            chk(mem[16'h390] == r0 && mem[16'h391] == r0 + 1, "R8", mem[16'h391], r0 + 1);
        end
        rd(2'd2, s);
        chk(s == 32'h2 && irq == 1'b0, "R9", s, 32'h2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule